// File: doc/BRIEF.md
# Total-Store-Order Commit Scheduler

This block is the memory side of a small shared-memory cluster. Every processor pushes its memory operations, in program order, into a queue of its own. Each cycle the scheduler picks at most one pending operation and performs it against a shared word memory. The choice follows operational total-store-order rules.

A load may overtake older stores from its own processor. When it does, it takes their data by forwarding. Plain stores leave the queue strictly in program order. An atomic read-modify-write is issued as two operations: an atomic load followed at once by its atomic store. A single global owner register holds the identity of an atomic load that has committed. While the register is set, no plain store from any processor may reach memory. Loads answer on a registered response port. Stores change only the internal memory.

Top module: `tso_commit_sched`

## Requirements
- R1: After reset every memory word reads as zero, no response is valid, and no queue reports full.
- R2: A load returns the value of the most recent store to its address, judged in its own processor's program order. That store may still be waiting in the queue, in which case its data is forwarded. Otherwise the value comes from memory.
- R3: Loads from one processor, including atomic loads, commit and respond in program order. An older uncommitted plain store does not hold a load back.
- R4: A plain store commits only when the atomic owner register is empty and every older operation from its processor has committed.
- R5: An atomic load commits only when it is the oldest uncommitted operation of its processor and the owner register is empty. It returns the memory value and sets the owner register to its processor and queue slot.
- R6: An atomic store commits only when the owner register holds its own processor and the slot just before its own. On commit it writes memory and clears the register.
- R7: At most one operation commits per cycle. A round-robin pointer starts at the processor after the last winner, so processors that stay eligible are served alternately.
- R8: A processor's full output is high while its queue holds eight operations that have not been retired. An issue is accepted only while full is low.
- R9: Processor p drives issue bits [2p+1:2p] of the kind field, with 00 for load, 01 for store, 10 for atomic load and 11 for atomic store. The address and data fields use slices of the same index. Each load or atomic load produces exactly one response, one cycle after it commits, tagged with p. Stores produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | NPROC | Per-processor issue strobe |
| iss_kind | input | 2*NPROC | Per-processor operation kind |
| iss_addr | input | AW*NPROC | Per-processor word address |
| iss_data | input | DW*NPROC | Per-processor store data |
| iss_full | output | NPROC | Per-processor queue-full backpressure |
| rsp_valid | output | 1 | Load response valid |
| rsp_proc | output | PW | Processor the response belongs to |
| rsp_data | output | DW | Loaded word |

## Verification
The owner checks take for granted that a processor issues each atomic store directly after its atomic load, and that it never issues while its full output is high. The stimulus builds every atomic pair as two adjacent entries of one processor's script. The driver reads full on the falling edge before it presents a new operation.

Random traffic gives each processor its own interleaved set of addresses. Under that condition a sequential model of each processor predicts every load value regardless of how commits interleave. Directed phases that share an address wait for the queues to drain between processors.

// File: rtl/tso_pkg.sv
`timescale 1ns/1ps
package tso_pkg;
  // Operation kinds carried on the issue port; bit 0 set means a memory write.
  typedef enum logic [1:0] {
    OP_LD  = 2'b00,
    OP_ST  = 2'b01,
    OP_ALD = 2'b10,
    OP_AST = 2'b11
  } op_kind_e;
endpackage

// File: rtl/tso_word_mem.sv
`timescale 1ns/1ps
module tso_word_mem #(
  parameter int NWORDS = 16,
  parameter int AW     = 4,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] word_q [NWORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) word_q[i] <= '0;
    end else if (we) begin
      word_q[waddr] <= wdata;
    end
  end

  assign rdata = word_q[raddr];
endmodule

// File: rtl/tso_rr_arb.sv
`timescale 1ns/1ps
module tso_rr_arb #(
  parameter int N  = 2,
  parameter int PW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [PW-1:0] gidx,
  output logic          any
);
  logic [PW-1:0] ptr_q, ptr_d;
  int            scan;

  always_comb begin
    any   = 1'b0;
    gidx  = '0;
    grant = '0;
    scan  = 0;
    for (int k = 0; k < N; k++) begin
      scan = int'(ptr_q) + k;
      if (scan >= N) scan = scan - N;
      if (!any && req[PW'(scan)]) begin
        any  = 1'b1;
        gidx = PW'(scan);
      end
    end
    if (any) grant[gidx] = 1'b1;
    ptr_d = ptr_q;
    if (any) ptr_d = (int'(gidx) == N-1) ? '0 : gidx + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/tso_op_queue.sv
`timescale 1ns/1ps
module tso_op_queue import tso_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int PW    = 1,
  parameter int PID   = 0,
  localparam int SW   = $clog2(DEPTH),
  localparam int CW   = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  op_kind_e      push_kind,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  output logic          full,
  input  logic          own_valid,
  input  logic [PW-1:0] own_proc,
  input  logic [SW-1:0] own_slot,
  input  logic          grant,
  output logic          req,
  output op_kind_e      req_kind,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic [SW-1:0] req_slot,
  output logic          fwd_hit,
  output logic [DW-1:0] fwd_data
);
  op_kind_e      kind_q [DEPTH];
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [DEPTH-1:0] done_q, done_d;
  logic [SW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop;
  logic          old_found, old_ok, ld_found, ld_plain;
  logic [SW-1:0] old_slot, ld_slot, pick_slot, scan_slot, fwd_slot;
  logic [CW-1:0] ld_off;

  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push_valid && !full;
  assign pop     = (cnt_q != '0) && done_q[head_q];

  // Oldest pending entry, and oldest pending load of either kind.
  always_comb begin
    old_found = 1'b0; old_slot = '0;
    ld_found  = 1'b0; ld_plain = 1'b0; ld_slot = '0; ld_off = '0;
    scan_slot = '0;
    for (int k = 0; k < DEPTH; k++) begin
      scan_slot = head_q + SW'(k);
      if ((CW'(k) < cnt_q) && !done_q[scan_slot]) begin
        if (!old_found) begin
          old_found = 1'b1;
          old_slot  = scan_slot;
        end
        if (!ld_found && (kind_q[scan_slot] == OP_LD || kind_q[scan_slot] == OP_ALD)) begin
          ld_found = 1'b1;
          ld_plain = (kind_q[scan_slot] == OP_LD);
          ld_slot  = scan_slot;
          ld_off   = CW'(k);
        end
      end
    end
  end

  // Youngest pending older write to the load's address wins the forward.
  always_comb begin
    fwd_hit  = 1'b0;
    fwd_data = '0;
    fwd_slot = '0;
    for (int k = 0; k < DEPTH; k++) begin
      fwd_slot = head_q + SW'(k);
      if (ld_found && (CW'(k) < ld_off) && !done_q[fwd_slot] &&
          (kind_q[fwd_slot] == OP_ST || kind_q[fwd_slot] == OP_AST) &&
          (addr_q[fwd_slot] == addr_q[ld_slot])) begin
        fwd_hit  = 1'b1;
        fwd_data = data_q[fwd_slot];
      end
    end
  end

  always_comb begin
    case (kind_q[old_slot])
      OP_ST, OP_ALD: old_ok = !own_valid;
      OP_AST:        old_ok = own_valid && (own_proc == PW'(PID)) &&
                              (own_slot == old_slot - SW'(1));
      default:       old_ok = 1'b1;
    endcase
    old_ok    = old_ok && old_found;
    req       = old_ok || (ld_found && ld_plain);
    pick_slot = old_ok ? old_slot : ld_slot;
  end

  assign req_kind = kind_q[pick_slot];
  assign req_addr = addr_q[pick_slot];
  assign req_data = data_q[pick_slot];
  assign req_slot = pick_slot;

  always_comb begin
    done_d = done_q;
    if (push_ok) done_d[tail_q]    = 1'b0;
    if (grant)   done_d[pick_slot] = 1'b1;
    head_d = pop     ? head_q + SW'(1) : head_q;
    tail_d = push_ok ? tail_q + SW'(1) : tail_q;
    cnt_d  = cnt_q + CW'(push_ok) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= done_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      kind_q[tail_q] <= push_kind;
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end
endmodule

// File: rtl/tso_commit_sched.sv
`timescale 1ns/1ps
module tso_commit_sched import tso_pkg::*; #(
  parameter int NPROC  = 2,
  parameter int QDEPTH = 8,
  parameter int NWORDS = 16,
  parameter int DW     = 32,
  parameter int AW     = $clog2(NWORDS),
  parameter int PW     = $clog2(NPROC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPROC-1:0]      iss_valid,
  input  logic [2*NPROC-1:0]    iss_kind,
  input  logic [AW*NPROC-1:0]   iss_addr,
  input  logic [DW*NPROC-1:0]   iss_data,
  output logic [NPROC-1:0]      iss_full,
  output logic                  rsp_valid,
  output logic [PW-1:0]         rsp_proc,
  output logic [DW-1:0]         rsp_data
);
  localparam int SW = $clog2(QDEPTH);

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic [NPROC-1:0] q_req, grant, q_fhit;
  op_kind_e         q_kind  [NPROC];
  logic [AW-1:0]    q_addr  [NPROC];
  logic [DW-1:0]    q_data  [NPROC];
  logic [SW-1:0]    q_slot  [NPROC];
  logic [DW-1:0]    q_fdata [NPROC];
  logic [PW-1:0]    gidx;
  logic             commit_valid, mem_we;
  op_kind_e         sel_kind;
  logic [AW-1:0]    sel_addr;
  logic [DW-1:0]    sel_data, mem_rdata;
  logic [SW-1:0]    sel_slot;
  logic             own_valid_q, own_valid_d;
  logic [PW-1:0]    own_proc_q, own_proc_d;
  logic [SW-1:0]    own_slot_q, own_slot_d;
  logic             rsp_valid_d;
  logic [DW-1:0]    rsp_data_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  for (genvar p = 0; p < NPROC; p++) begin : g_q
    tso_op_queue #(
      .DEPTH(QDEPTH), .AW(AW), .DW(DW), .PW(PW), .PID(p)
    ) q_i (
      .clk       (clk),
      .rst_n     (rst_ni),
      .push_valid(iss_valid[p]),
      .push_kind (op_kind_e'(iss_kind[2*p +: 2])),
      .push_addr (iss_addr[AW*p +: AW]),
      .push_data (iss_data[DW*p +: DW]),
      .full      (iss_full[p]),
      .own_valid (own_valid_q),
      .own_proc  (own_proc_q),
      .own_slot  (own_slot_q),
      .grant     (grant[p]),
      .req       (q_req[p]),
      .req_kind  (q_kind[p]),
      .req_addr  (q_addr[p]),
      .req_data  (q_data[p]),
      .req_slot  (q_slot[p]),
      .fwd_hit   (q_fhit[p]),
      .fwd_data  (q_fdata[p])
    );
  end

  tso_rr_arb #(.N(NPROC), .PW(PW)) arb_i (
    .clk  (clk),
    .rst_n(rst_ni),
    .req  (q_req),
    .grant(grant),
    .gidx (gidx),
    .any  (commit_valid)
  );

  assign sel_kind = q_kind[gidx];
  assign sel_addr = q_addr[gidx];
  assign sel_data = q_data[gidx];
  assign sel_slot = q_slot[gidx];
  assign mem_we   = commit_valid && (sel_kind == OP_ST || sel_kind == OP_AST);

  tso_word_mem #(.NWORDS(NWORDS), .AW(AW), .DW(DW)) mem_i (
    .clk  (clk),
    .rst_n(rst_ni),
    .we   (mem_we),
    .waddr(sel_addr),
    .wdata(sel_data),
    .raddr(sel_addr),
    .rdata(mem_rdata)
  );

  always_comb begin
    own_valid_d = own_valid_q;
    own_proc_d  = own_proc_q;
    own_slot_d  = own_slot_q;
    if (commit_valid && sel_kind == OP_ALD) begin
      own_valid_d = 1'b1;
      own_proc_d  = gidx;
      own_slot_d  = sel_slot;
    end else if (commit_valid && sel_kind == OP_AST) begin
      own_valid_d = 1'b0;
    end
    rsp_valid_d = commit_valid && (sel_kind == OP_LD || sel_kind == OP_ALD);
    rsp_data_d  = q_fhit[gidx] ? q_fdata[gidx] : mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      own_valid_q <= 1'b0;
      own_proc_q  <= '0;
      own_slot_q  <= '0;
      rsp_valid   <= 1'b0;
      rsp_proc    <= '0;
      rsp_data    <= '0;
    end else begin
      own_valid_q <= own_valid_d;
      own_proc_q  <= own_proc_d;
      own_slot_q  <= own_slot_d;
      rsp_valid   <= rsp_valid_d;
      if (rsp_valid_d) begin
        rsp_proc <= gidx;
        rsp_data <= rsp_data_d;
      end
    end
  end
endmodule

// File: rtl/tso_sched_chk.sv
`timescale 1ns/1ps
module tso_sched_chk #(
  parameter int NPROC = 2,
  parameter int PW    = 1,
  parameter int SW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             commit_valid,
  input logic [1:0]       commit_kind,
  input logic [PW-1:0]    commit_proc,
  input logic [SW-1:0]    commit_slot,
  input logic             own_valid,
  input logic [PW-1:0]    own_proc,
  input logic [SW-1:0]    own_slot,
  input logic [NPROC-1:0] grant,
  input logic             rsp_valid
);
  p_store_owner_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_kind == 2'b01) |-> !own_valid);

  p_aload_owner_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_kind == 2'b10) |-> !own_valid);

  p_aload_sets_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_kind == 2'b10) |=> (own_valid && own_proc == $past(commit_proc)));

  p_astore_matches_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_kind == 2'b11) |->
      (own_valid && own_proc == commit_proc && own_slot == commit_slot - SW'(1)));

  p_astore_clears_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_kind == 2'b11) |=> !own_valid);

  p_single_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_rsp_after_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(commit_valid && !commit_kind[0]));
endmodule

bind tso_commit_sched tso_sched_chk #(.NPROC(NPROC), .PW(PW), .SW(SW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_ni),
  .commit_valid(commit_valid),
  .commit_kind (sel_kind),
  .commit_proc (gidx),
  .commit_slot (sel_slot),
  .own_valid   (own_valid_q),
  .own_proc    (own_proc_q),
  .own_slot    (own_slot_q),
  .grant       (grant),
  .rsp_valid   (rsp_valid)
);

// File: tb/tso_commit_sched_tb_top.sv
`timescale 1ns/1ps
module tso_commit_sched_tb_top;
  localparam int NP = 2, NW = 16, DW = 32, AW = 4, PW = 1, MAXOPS = 1024;
  localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_ALD = 2'b10, K_AST = 2'b11;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NP-1:0]     b_valid;
  logic [2*NP-1:0]   b_kind;
  logic [AW*NP-1:0]  b_addr;
  logic [DW*NP-1:0]  b_data;
  logic [NP-1:0]     full;
  logic              rsp_valid;
  logic [PW-1:0]     rsp_proc;
  logic [DW-1:0]     rsp_data;

  always #2.5 clk = ~clk;

  tso_commit_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(b_valid), .iss_kind(b_kind), .iss_addr(b_addr), .iss_data(b_data),
    .iss_full(full),
    .rsp_valid(rsp_valid), .rsp_proc(rsp_proc), .rsp_data(rsp_data)
  );

  logic [1:0]    s_kind [NP][MAXOPS];
  logic [AW-1:0] s_addr [NP][MAXOPS];
  logic [DW-1:0] s_data [NP][MAXOPS];
  int            s_len [NP];
  int            s_ptr [NP];
  logic [DW-1:0] e_val [NP][MAXOPS];
  string         e_tag [NP][MAXOPS];
  int            e_len [NP];
  int            e_rd  [NP];
  logic [DW-1:0] mdl   [NW];

  int  n_chk = 0, n_bad = 0;
  bit  timed_out = 1'b0, mon_on = 1'b0, rr_on = 1'b0;
  int  rr_cnt = 0, rr_same = 0, rr_last = -1, mp;
  logic [NP-1:0] saw_full;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Append to a processor's script and advance its sequential model.
  task automatic add_op(input int p, input logic [1:0] k, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string tag);
    s_kind[p][s_len[p]] = k;
    s_addr[p][s_len[p]] = a;
    s_data[p][s_len[p]] = d;
    s_len[p]++;
    if (k == K_LD || k == K_ALD) begin
      e_val[p][e_len[p]] = mdl[a];
      e_tag[p][e_len[p]] = tag;
      e_len[p]++;
    end else begin
      mdl[a] = d;
    end
  endtask

  task automatic run(input int gap);
    bit busy;
    do begin
      @(negedge clk);
      busy = 1'b0;
      for (int p = 0; p < NP; p++) begin
        b_valid[p] = 1'b0;
        if (s_ptr[p] < s_len[p]) busy = 1'b1;
        if (s_ptr[p] < s_len[p] && !full[p] && int'($urandom % 100) >= gap) begin
          b_valid[p]           = 1'b1;
          b_kind[2*p +: 2]     = s_kind[p][s_ptr[p]];
          b_addr[AW*p +: AW]   = s_addr[p][s_ptr[p]];
          b_data[DW*p +: DW]   = s_data[p][s_ptr[p]];
          s_ptr[p]++;
        end
      end
    end while (busy && !timed_out);
    @(negedge clk);
    b_valid = '0;
    while (!timed_out && (e_rd[0] < e_len[0] || e_rd[1] < e_len[1])) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic random_ops(input int n);
    for (int p = 0; p < NP; p++) begin
      for (int i = 0; i < n; i++) begin
        int r;
        logic [AW-1:0] a;
        r = int'($urandom % 10);
        a = AW'(int'($urandom % (NW/NP)) * NP + p);
        if (r < 4 || r == 9) add_op(p, K_LD, a, '0, "R3 random load in program order");
        else if (r < 8)      add_op(p, K_ST, a, $urandom, "");
        else begin
          add_op(p, K_ALD, a, '0, "R5 random atomic load");
          add_op(p, K_AST, a, $urandom, "");
        end
      end
    end
  endtask

  // Response monitor: compares against the per-processor expected list.
  always @(negedge clk) begin
    if (mon_on) begin
      for (int p = 0; p < NP; p++) if (full[p]) saw_full[p] = 1'b1;
      if (rsp_valid) begin
        mp = int'(rsp_proc);
        if (e_rd[mp] >= e_len[mp]) begin
          check(1'b0, "R9 response with no pending load", rsp_data, '0);
        end else begin
          check(rsp_data == e_val[mp][e_rd[mp]], e_tag[mp][e_rd[mp]], rsp_data, e_val[mp][e_rd[mp]]);
          e_rd[mp]++;
        end
        if (rr_on) begin
          rr_cnt++;
          if (mp == rr_last) rr_same++;
          rr_last = mp;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    timed_out = 1'b1;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) begin
      s_len[p] = 0; s_ptr[p] = 0; e_len[p] = 0; e_rd[p] = 0;
    end
    for (int i = 0; i < NW; i++) mdl[i] = '0;
    saw_full = '0;
    rst_n   = 1'b0;
    b_valid = '0; b_kind = '0; b_addr = '0; b_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
    check(full == '0, "R1 no queue full after reset", 32'(full), 32'd0);
    mon_on = 1'b1;

    add_op(0, K_LD, 4'd9, '0, "R1 memory cleared to zero");
    run(0);

    // Own pending stores forward to younger loads.
    add_op(0, K_ST, 4'd3, 32'h11, "");
    add_op(0, K_LD, 4'd3, '0, "R2 load sees pending own store");
    add_op(0, K_ST, 4'd3, 32'h22, "");
    add_op(0, K_ST, 4'd3, 32'h33, "");
    add_op(0, K_LD, 4'd3, '0, "R2 youngest of two own stores");
    add_op(0, K_ST, 4'd5, 32'h7, "");
    add_op(0, K_LD, 4'd5, '0, "R2 forward on second address");
    run(0);

    add_op(1, K_LD, 4'd3, '0, "R4 store of other processor reached memory");
    run(0);

    // Atomic pair on one processor while the other stores elsewhere.
    add_op(1, K_ALD, 4'd3, '0, "R5 atomic load returns memory word");
    add_op(1, K_AST, 4'd3, 32'h99, "");
    add_op(1, K_LD, 4'd3, '0, "R6 load after own atomic pair");
    add_op(0, K_ST, 4'd7, 32'hab, "");
    add_op(0, K_LD, 4'd7, '0, "R4 store held by owner then forwarded");
    run(0);

    add_op(0, K_LD, 4'd3, '0, "R6 atomic store committed to memory");
    add_op(1, K_LD, 4'd7, '0, "R4 store committed after owner cleared");
    run(0);

    // Both processors keep loads pending: commits must alternate.
    for (int i = 0; i < 6; i++)
      for (int p = 0; p < NP; p++) add_op(p, K_LD, AW'(p), '0, "R7 load during alternation");
    rr_on = 1'b1; rr_last = -1; rr_cnt = 0; rr_same = 0;
    run(0);
    rr_on = 1'b0;
    check(rr_same == 0, "R7 consecutive responses from one processor", 32'(rr_same), 32'd0);
    check(rr_cnt == 12, "R7 response count in alternation", 32'(rr_cnt), 32'd12);

    saw_full = '0;
    random_ops(150);
    run(0);
    check(saw_full != '0, "R8 full seen under saturating issue", 32'(saw_full), 32'd1);

    random_ops(150);
    run(50);

    for (int p = 0; p < NP; p++)
      check(e_rd[p] == e_len[p], "R9 every load answered once", 32'(e_rd[p]), 32'(e_len[p]));

    if (timed_out) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule